// File: doc/BRIEF.md
# Switch State Reporter with Change Interrupt

This block sits on a 32-bit APB-style register bus and reports the state of one named switch to a processor. It occupies a 4 KB address window and drives a single interrupt line. Outside logic loads a new 32-bit switch state through a one-cycle update port. Each such update stores the value and marks a change as pending. While interrupts are enabled, a pending change raises the interrupt.

A switch can be built as input-only or as output-capable. On an output-capable switch, a processor write to the state register goes out to an external handler over a valid/ready request port. The handler returns the resulting state on a response port, and the bus write stalls until that response arrives. The block takes the returned value as the new state only when it differs from the current one.

The block also exposes the length of the switch's name as a constant and accepts a name-pointer write, which it ignores. Any access the register map does not define ends with an error response and changes nothing.

Top module: `sw_notify`

## Requirements
- R1: After reset the state register reads 0, no change is pending, interrupts are disabled and `irq` is 0.
- R2: A read of offset 0x00 returns the parameter `NAME_LEN`.
- R3: A read of offset 0x08 returns 1 in bit 0 when `CAN_WRITE` is 1 and 0 otherwise. All other bits read 0.
- R4: A cycle with `ext_upd_valid` high stores `ext_upd_state`, which later reads of offset 0x0C return, and marks a change pending. `irq` rises only if interrupts are enabled.
- R5: A read of offset 0x10 returns 1 only when a change is pending and interrupts are enabled. That read clears the pending change and drops `irq`. In every other case the read returns 0 and the pending change is kept.
- R6: A write to offset 0x14 sets the interrupt enable from bit 0 of the written data and ignores the other bits. While a change is pending, `irq` follows the new enable value.
- R7: On an output-capable switch, a write to offset 0x0C raises `hnd_req_valid` with the written data. The request is held, with its data stable, until `hnd_req_ready` is seen. `pready` stays low until `hnd_rsp_valid` arrives.
- R8: When the handler response differs from the current state, the response becomes the new state and a change is marked pending. An equal response leaves the state and the pending change as they were.
- R9: These accesses complete with `pslverr` high in the same cycle as `pready`, and no register changes: a write to offset 0x0C on an input-only switch, a read of 0x04 or 0x14, a write of 0x00, 0x08 or 0x10, and any other offset, including a misaligned one.
- R10: A write to offset 0x04 completes without error and has no effect on the state, the pending change or `irq`.
- R11: An external update has priority. If it coincides with a clearing status read, the change stays pending. If it coincides with a handler response, the external value becomes the state.
- R12: `irq` is a register output. It changes in the cycle after the event that causes it and always equals "change pending AND interrupts enabled".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write (1) or read (0) |
| paddr | input | ADDR_W | Byte offset within the window |
| pwdata | input | DATA_W | Bus write data |
| prdata | output | DATA_W | Bus read data |
| pready | output | 1 | Transfer completes this cycle |
| pslverr | output | 1 | Error response |
| irq | output | 1 | Change interrupt |
| ext_upd_valid | input | 1 | Load a new switch state this cycle |
| ext_upd_state | input | DATA_W | New switch state |
| hnd_req_valid | output | 1 | Write request to the external handler |
| hnd_req_data | output | DATA_W | Value written by the processor |
| hnd_req_ready | input | 1 | Handler accepts the request |
| hnd_rsp_valid | input | 1 | Handler response present |
| hnd_rsp_state | input | DATA_W | State returned by the handler |

## Verification
The bench builds two instances. The main one uses `CAN_WRITE=1` and `NAME_LEN=9`, and it exercises the handler round trip, stalling, change detection and collisions with external updates. A second instance uses `CAN_WRITE=0` and `NAME_LEN=5`. It brings in reach the flags bit reading 0, a different name length, and the error on a state write with no handler request issued. The bench's handler returns the low byte of the written value, so both a changed result and an equal result can be produced on demand.

// File: rtl/sw_notify_pkg.sv
package sw_notify_pkg;

    localparam logic [11:0] OFS_LEN   = 12'h000;
    localparam logic [11:0] OFS_PTR   = 12'h004;
    localparam logic [11:0] OFS_FLAG  = 12'h008;
    localparam logic [11:0] OFS_STATE = 12'h00C;
    localparam logic [11:0] OFS_STAT  = 12'h010;
    localparam logic [11:0] OFS_EN    = 12'h014;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_LEN_RD,
        OP_PTR_WR,
        OP_FLAG_RD,
        OP_STATE_RD,
        OP_STATE_WR,
        OP_STAT_RD,
        OP_EN_WR,
        OP_BAD
    } op_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_REQ,
        HS_RSP
    } hs_e;

    typedef struct packed {
        logic pend;
        logic en;
        logic irq;
    } ctl_t;

endpackage

// File: rtl/sw_notify_dec.sv
module sw_notify_dec
    import sw_notify_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit CAN_WRITE = 1'b1
) (
    input  logic              access,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op
);

    always_comb begin
        op = OP_NONE;
        if (access) begin
            op = OP_BAD;
            if (addr == ADDR_W'(OFS_LEN) && !write) begin
                op = OP_LEN_RD;
            end else if (addr == ADDR_W'(OFS_PTR) && write) begin
                op = OP_PTR_WR;
            end else if (addr == ADDR_W'(OFS_FLAG) && !write) begin
                op = OP_FLAG_RD;
            end else if (addr == ADDR_W'(OFS_STATE) && !write) begin
                op = OP_STATE_RD;
            end else if (addr == ADDR_W'(OFS_STATE) && write && CAN_WRITE) begin
                op = OP_STATE_WR;
            end else if (addr == ADDR_W'(OFS_STAT) && !write) begin
                op = OP_STAT_RD;
            end else if (addr == ADDR_W'(OFS_EN) && write) begin
                op = OP_EN_WR;
            end
        end
    end

endmodule

// File: rtl/sw_notify_hs.sv
module sw_notify_hs
    import sw_notify_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] wdata,
    input  logic              req_ready,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              idle
);

    typedef struct packed {
        hs_e               fsm;
        logic [DATA_W-1:0] data;
    } hs_t;

    hs_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        unique case (h_q.fsm)
            HS_IDLE: if (start) begin
                h_d.fsm  = HS_REQ;
                h_d.data = wdata;
            end
            HS_REQ:  if (req_ready) h_d.fsm = HS_RSP;
            HS_RSP:  if (rsp_valid) h_d.fsm = HS_IDLE;
            default: h_d.fsm = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '{fsm: HS_IDLE, data: '0};
        end else begin
            h_q <= h_d;
        end
    end

    assign req_valid = (h_q.fsm == HS_REQ);
    assign req_data  = h_q.data;
    assign done      = (h_q.fsm == HS_RSP) && rsp_valid;
    assign idle      = (h_q.fsm == HS_IDLE);

endmodule

// File: rtl/sw_notify.sv
module sw_notify
    import sw_notify_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NAME_LEN  = 9,
    parameter bit CAN_WRITE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq,
    input  logic              ext_upd_valid,
    input  logic [DATA_W-1:0] ext_upd_state,
    output logic              hnd_req_valid,
    output logic [DATA_W-1:0] hnd_req_data,
    input  logic              hnd_req_ready,
    input  logic              hnd_rsp_valid,
    input  logic [DATA_W-1:0] hnd_rsp_state
);

    localparam logic [DATA_W-1:0] LEN_VAL  = DATA_W'(NAME_LEN);
    localparam logic [DATA_W-1:0] FLAG_VAL = DATA_W'(CAN_WRITE);

    typedef struct packed {
        logic [DATA_W-1:0] state;
        ctl_t              ctl;
    } regs_t;

    regs_t r_d, r_q;
    op_e   op;
    logic  access;
    logic  hs_start, hs_done, hs_idle;

    assign access = psel && penable;

    sw_notify_dec #(
        .ADDR_W   (ADDR_W),
        .CAN_WRITE(CAN_WRITE)
    ) u_dec (
        .access(access),
        .write (pwrite),
        .addr  (paddr),
        .op    (op)
    );

    assign hs_start = (op == OP_STATE_WR) && hs_idle;

    generate
        if (CAN_WRITE) begin : g_hs
            sw_notify_hs #(
                .DATA_W(DATA_W)
            ) u_hs (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (hs_start),
                .wdata    (pwdata),
                .req_ready(hnd_req_ready),
                .rsp_valid(hnd_rsp_valid),
                .req_valid(hnd_req_valid),
                .req_data (hnd_req_data),
                .done     (hs_done),
                .idle     (hs_idle)
            );
        end else begin : g_no_hs
            assign hnd_req_valid = 1'b0;
            assign hnd_req_data  = '0;
            assign hs_done       = 1'b0;
            assign hs_idle       = 1'b1;
        end
    endgenerate

    // Next-value computation: bus effects first, external update last (priority).
    always_comb begin
        r_d = r_q;
        unique case (op)
            OP_STAT_RD: if (r_q.ctl.pend && r_q.ctl.en) r_d.ctl.pend = 1'b0;
            OP_EN_WR:   r_d.ctl.en = pwdata[0];
            OP_STATE_WR: if (hs_done && (hnd_rsp_state != r_q.state)) begin
                r_d.state    = hnd_rsp_state;
                r_d.ctl.pend = 1'b1;
            end
            default: ;
        endcase
        if (ext_upd_valid) begin
            r_d.state    = ext_upd_state;
            r_d.ctl.pend = 1'b1;
        end
        r_d.ctl.irq = r_d.ctl.pend && r_d.ctl.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (op)
            OP_LEN_RD:   prdata = LEN_VAL;
            OP_FLAG_RD:  prdata = FLAG_VAL;
            OP_STATE_RD: prdata = r_q.state;
            OP_STAT_RD:  prdata = DATA_W'(r_q.ctl.pend && r_q.ctl.en);
            default:     prdata = '0;
        endcase
    end

    assign pready  = (op == OP_STATE_WR) ? hs_done : 1'b1;
    assign pslverr = (op == OP_BAD);
    assign irq     = r_q.ctl.irq;

endmodule

// File: rtl/sw_notify_chk.sv
module sw_notify_chk
    import sw_notify_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              pready,
    input logic              pslverr,
    input logic              irq,
    input logic              ext_upd_valid,
    input logic [DATA_W-1:0] ext_upd_state,
    input logic              hnd_req_valid,
    input logic              hnd_req_ready,
    input logic [DATA_W-1:0] hnd_req_data,
    input logic [DATA_W-1:0] state_q,
    input logic              pend_q,
    input logic              en_q
);

    a_r4_update_stored: assert property (@(posedge clk) disable iff (!rst_n)
        ext_upd_valid |=> (state_q == $past(ext_upd_state)) && pend_q);

    a_r5_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == ADDR_W'(OFS_STAT) && pend_q && en_q
         && !ext_upd_valid) |=> !irq && !pend_q);

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hnd_req_valid && !hnd_req_ready) |=> hnd_req_valid && $stable(hnd_req_data));

    a_r7_stall_during_req: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && hnd_req_valid) |-> !pready);

    a_r9_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready && psel && penable);

    a_r9_err_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |=> $stable(en_q));

endmodule

bind sw_notify sw_notify_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pready       (pready),
    .pslverr      (pslverr),
    .irq          (irq),
    .ext_upd_valid(ext_upd_valid),
    .ext_upd_state(ext_upd_state),
    .hnd_req_valid(hnd_req_valid),
    .hnd_req_ready(hnd_req_ready),
    .hnd_req_data (hnd_req_data),
    .state_q      (r_q.state),
    .pend_q       (r_q.ctl.pend),
    .en_q         (r_q.ctl.en)
);

// File: tb/sw_notify_tb.sv
module sw_notify_tb;
    localparam int AW = 12;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n = 1'b0;

    logic psel = 0, psel2 = 0, penable = 0, pwrite = 0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata, prdata2;
    logic pready, pready2, pslverr, pslverr2, irq, irq2;

    logic upd_a = 0, upd_b = 0;
    logic [DW-1:0] upd_a_val = '0, upd_b_val = '0;
    logic ext_upd_valid;
    logic [DW-1:0] ext_upd_state;
    assign ext_upd_valid = upd_a | upd_b;
    assign ext_upd_state = upd_b ? upd_b_val : upd_a_val;

    logic hnd_req_valid, hnd_req_ready = 0, hnd_rsp_valid = 0;
    logic [DW-1:0] hnd_req_data, hnd_rsp_state = '0;
    logic ro_req_valid;
    logic [DW-1:0] ro_req_data;

    sw_notify #(.ADDR_W(AW), .DATA_W(DW), .NAME_LEN(9), .CAN_WRITE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq), .ext_upd_valid(ext_upd_valid),
        .ext_upd_state(ext_upd_state), .hnd_req_valid(hnd_req_valid),
        .hnd_req_data(hnd_req_data), .hnd_req_ready(hnd_req_ready),
        .hnd_rsp_valid(hnd_rsp_valid), .hnd_rsp_state(hnd_rsp_state));

    sw_notify #(.ADDR_W(AW), .DATA_W(DW), .NAME_LEN(5), .CAN_WRITE(1'b0)) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .psel(psel2), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata2), .pready(pready2),
        .pslverr(pslverr2), .irq(irq2), .ext_upd_valid(1'b0),
        .ext_upd_state('0), .hnd_req_valid(ro_req_valid),
        .hnd_req_data(ro_req_data), .hnd_req_ready(1'b0),
        .hnd_rsp_valid(1'b0), .hnd_rsp_state('0));

    int n_chk = 0, n_bad = 0, c_chk = 0, c_bad = 0;

    // Behavioural reference model, advanced on completed transfers.
    logic [DW-1:0] m_state = '0;
    bit m_pend = 0, m_en = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (psel && penable && pready && !pslverr) begin
                if (!pwrite && paddr == 12'h010 && m_pend && m_en) m_pend = 0;
                if (pwrite && paddr == 12'h014) m_en = pwdata[0];
                if (pwrite && paddr == 12'h00C && hnd_rsp_state != m_state) begin
                    m_state = hnd_rsp_state;
                    m_pend  = 1;
                end
            end
            if (ext_upd_valid) begin
                m_state = ext_upd_state;
                m_pend  = 1;
            end
        end
    end

    // R12: interrupt compared against the model on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            c_chk++;
            if (irq !== (m_pend && m_en)) begin
                c_bad++;
                $display("FAIL R12 irq per cycle act=%b exp=%b", irq, m_pend && m_en);
            end
        end
    end

    // External handler: returns the low byte of the written value.
    bit collide = 0;
    logic [DW-1:0] collide_val = '0;
    logic [DW-1:0] seen_req = '0;
    int n_req = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (hnd_req_valid && !hnd_req_ready) begin
                hnd_req_ready = 1;
                seen_req = hnd_req_data;
                n_req++;
                @(negedge clk);
                hnd_req_ready = 0;
                @(negedge clk);
                hnd_rsp_valid = 1;
                hnd_rsp_state = {24'h0, seen_req[7:0]};
                if (collide) begin
                    upd_b = 1;
                    upd_b_val = collide_val;
                end
                @(negedge clk);
                hnd_rsp_valid = 0;
                upd_b = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input bit ro, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input bit upd, input logic [DW-1:0] uv,
                       output logic [DW-1:0] rd, output logic err, output int waits);
        @(negedge clk);
        if (ro) psel2 = 1; else psel = 1;
        pwrite = wr; paddr = a; pwdata = wd;
        @(negedge clk);
        penable = 1;
        if (upd) begin upd_a = 1; upd_a_val = uv; end
        waits = 0;
        #1;
        while (!(ro ? pready2 : pready)) begin
            @(negedge clk);
            upd_a = 0;
            waits++;
            #1;
        end
        rd  = ro ? prdata2 : prdata;
        err = ro ? pslverr2 : pslverr;
        @(negedge clk);
        psel = 0; psel2 = 0; penable = 0; upd_a = 0;
    endtask

    task automatic rchk(input bit ro, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input string tag);
        logic [DW-1:0] rd; logic err; int w;
        bus(ro, 0, a, '0, 0, '0, rd, err, w);
        chk(tag, rd, exp);
        chk({tag, " err"}, {31'b0, err}, 0);
    endtask

    task automatic wchk(input bit ro, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit exp_err, input string tag);
        logic [DW-1:0] rd; logic err; int w;
        bus(ro, 1, a, wd, 0, '0, rd, err, w);
        chk(tag, {31'b0, err}, {31'b0, exp_err});
    endtask

    task automatic errrd(input bit ro, input logic [AW-1:0] a, input string tag);
        logic [DW-1:0] rd; logic err; int w;
        bus(ro, 0, a, '0, 0, '0, rd, err, w);
        chk(tag, {31'b0, err}, 1);
    endtask

    task automatic pulse(input logic [DW-1:0] v);
        @(negedge clk);
        upd_a = 1; upd_a_val = v;
        @(negedge clk);
        upd_a = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL R7 watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk + c_chk + 1, n_bad + c_bad + 1);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd; logic err; int w, req0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 irq after reset", {31'b0, irq}, 0);
        rchk(0, 12'h00C, 32'h0, "R1 state after reset");
        rchk(0, 12'h010, 32'h0, "R1 status after reset");
        rchk(0, 12'h000, 32'd9, "R2 name length");
        rchk(1, 12'h000, 32'd5, "R2 name length input-only");
        rchk(0, 12'h008, 32'h1, "R3 flags output-capable");
        rchk(1, 12'h008, 32'h0, "R3 flags input-only");

        pulse(32'h0000_A5A5);
        rchk(0, 12'h00C, 32'h0000_A5A5, "R4 state after update");
        chk("R4 irq stays low while disabled", {31'b0, irq}, 0);
        rchk(0, 12'h010, 32'h0, "R5 status while disabled");
        wchk(0, 12'h014, 32'h3, 0, "R6 enable write");
        chk("R6 irq follows enable", {31'b0, irq}, 1);
        rchk(0, 12'h010, 32'h1, "R5 status pending+enabled");
        chk("R5 irq cleared", {31'b0, irq}, 0);
        rchk(0, 12'h010, 32'h0, "R5 second status read");

        wchk(0, 12'h014, 32'h0, 0, "R6 disable");
        pulse(32'h11);
        chk("R6 irq low when disabled", {31'b0, irq}, 0);
        wchk(0, 12'h014, 32'h1, 0, "R6 enable with pending");
        chk("R6 irq rises with enable", {31'b0, irq}, 1);
        wchk(0, 12'h014, 32'h0, 0, "R6 disable with pending");
        chk("R6 irq falls with enable", {31'b0, irq}, 0);
        wchk(0, 12'h014, 32'hFFFF_FFFE, 0, "R6 only bit 0 used");
        chk("R6 irq low for bit0=0", {31'b0, irq}, 0);
        wchk(0, 12'h014, 32'h1, 0, "R6 re-enable");
        rchk(0, 12'h010, 32'h1, "R5 clear pending");

        wchk(0, 12'h004, 32'hDEAD_0000, 0, "R10 name pointer write");
        rchk(0, 12'h00C, 32'h11, "R10 state unchanged");
        chk("R10 irq unchanged", {31'b0, irq}, 0);

        bus(0, 1, 12'h00C, 32'h1234, 0, '0, rd, err, w);
        chk("R7 no error", {31'b0, err}, 0);
        chk("R7 bus stalled", {31'b0, w > 0}, 1);
        chk("R7 request data", seen_req, 32'h1234);
        rchk(0, 12'h00C, 32'h34, "R8 state from handler");
        chk("R8 irq on change", {31'b0, irq}, 1);
        rchk(0, 12'h010, 32'h1, "R8 pending after change");
        bus(0, 1, 12'h00C, 32'h5534, 0, '0, rd, err, w);
        rchk(0, 12'h010, 32'h0, "R8 equal result no pending");
        rchk(0, 12'h00C, 32'h34, "R8 state kept");

        req0 = n_req;
        errrd(0, 12'h004, "R9 read name pointer");
        errrd(0, 12'h014, "R9 read enable");
        errrd(0, 12'h020, "R9 undefined offset");
        errrd(0, 12'h00E, "R9 misaligned offset");
        errrd(0, 12'hFFC, "R9 top of window");
        wchk(0, 12'h000, 32'h0, 1, "R9 write name length");
        wchk(0, 12'h008, 32'h0, 1, "R9 write flags");
        wchk(0, 12'h010, 32'h0, 1, "R9 write status");
        wchk(1, 12'h00C, 32'h77, 1, "R9 state write input-only");
        chk("R9 no handler request", n_req, req0);
        rchk(0, 12'h00C, 32'h34, "R9 state unchanged");
        pulse(32'h42);
        chk("R9 enable survived errors", {31'b0, irq}, 1);
        rchk(0, 12'h010, 32'h1, "R9 clear");

        pulse(32'h66);
        bus(0, 0, 12'h010, '0, 1, 32'h77, rd, err, w);
        chk("R11 status read with update", rd, 32'h1);
        chk("R11 irq kept", {31'b0, irq}, 1);
        rchk(0, 12'h00C, 32'h77, "R11 update value");
        rchk(0, 12'h010, 32'h1, "R11 still pending");
        chk("R11 irq cleared", {31'b0, irq}, 0);

        collide = 1; collide_val = 32'hBEEF;
        bus(0, 1, 12'h00C, 32'h99, 0, '0, rd, err, w);
        collide = 0;
        rchk(0, 12'h00C, 32'hBEEF, "R11 update beats handler");
        rchk(0, 12'h010, 32'h1, "R11 pending after collision");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk + c_chk, n_bad + c_bad);
        $finish;
    end
endmodule